// File: doc/BRIEF.md
# Valley Lockout and Frequency Foldback Selector

This block sits in the digital core of a quasi-resonant flyback controller and decides when the power switch turns on again after each conduction cycle. It receives a digitised feedback level, a pulse each time the drain ringing reaches a valley, and a strobe at the end of every conduction cycle. From the feedback level it picks which valley restarts the switch. Heavy load restarts at the first valley. As the load drops, the restart moves out step by step to later valleys, up to a configurable limit (six by default).

When feedback falls below a lower threshold, the block stops waiting for valleys. It raises a freeze flag so the peak-current setpoint stays fixed, and it times the off period with a clock counter instead. The off period grows as feedback keeps dropping. If the off period would exceed the ceiling that keeps the switching frequency above its floor (25 kHz in a typical system), the block enters skip mode and issues no turn-on pulses. It then checks the feedback again each time a full floor period has passed.

The valley step thresholds, the hysteresis band, the foldback threshold, the off-time law and the floor period are all parameters. The defaults use feedback codes of 10 mV per LSB, so the first valley step is at code 140 (1.4 V) and foldback starts at code 80 (0.8 V).

Top module: `vly_foldback_sel`

## Requirements
- R1: After reset, valley_idx is 1, freeze is 0, skip is 0 and turn_on is 0.
- R2: While freeze is 0, turn_on goes high in the cycle after the N-th valley_pulse that follows a cycle_end, where N is valley_idx. A valley_pulse in the same cycle as cycle_end is not counted. Pulses after the turn-on and before the next cycle_end are ignored.
- R3: Going to a higher index, the index chosen at cycle_end is 1 plus the number of steps k = 2..VALLEY_MAX whose threshold LOCK_TOP - (k-2)*LOCK_STEP is above the feedback code. With the defaults these thresholds are 140, 130, 120, 110 and 100.
- R4: Going to a lower index, the index drops only to 1 plus the number of steps whose threshold plus HYST (4) is above the feedback code. If neither rule applies, the index is kept.
- R5: The valley index, the mode and the latched off time change only at a cycle_end, or at a skip-mode re-evaluation. Feedback changes inside an off period have no effect on that period.
- R6: From valley mode, a cycle_end with a feedback code below FOLD_TH (80) sets freeze. Freeze clears only at a cycle_end with a code of at least FOLD_TH+HYST (84).
- R7: While frozen and not skipping, turn_on goes high exactly BASE_OFF + (FOLD_TH - fb)*OFF_GAIN clocks after the cycle_end edge. A code of FOLD_TH or above counts as a difference of 0. Valley pulses are ignored in this mode.
- R8: If the off time computed in foldback exceeds MAX_OFF (100) clocks, skip is set and turn_on stays low. In skip mode the feedback is re-evaluated every MAX_OFF clocks, so skip mode ends without any cycle_end once the off time fits again.
- R9: turn_on is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_code | input | FB_W | Digitised feedback level |
| valley_pulse | input | 1 | One-cycle pulse per detected drain valley |
| cycle_end | input | 1 | One-cycle strobe at the end of conduction |
| turn_on | output | 1 | One-cycle request to turn the switch on |
| valley_idx | output | $clog2(VALLEY_MAX+1) | Valley that starts the next cycle (1-based) |
| freeze | output | 1 | Current setpoint frozen (foldback or skip) |
| skip | output | 1 | Frequency floor reached, no pulses |

## Verification
A cycle_end and a valley_pulse can arrive in the same clock cycle. In that case the new cycle boundary must win, and the pulse must not count toward the next turn-on. The bench drives both inputs together at every point of a full feedback sweep, first downward and then upward. It then requires the turn-on to appear exactly on the N-th later pulse. In skip mode, the floor-period re-evaluation lands in the same cycle in which the timer would otherwise keep counting. The bench changes feedback in the middle of a skip period and expects foldback timing to restart from that internal boundary.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [1:0] {
    VFS_VALLEY = 2'd0,
    VFS_FOLD   = 2'd1,
    VFS_SKIP   = 2'd2
  } vfs_mode_e;
endpackage

// File: rtl/vfs_level_map.sv
module vfs_level_map
  import vfs_pkg::*;
#(
  parameter int FB_W      = 8,
  parameter int VALLEY_MAX = 6,
  parameter int VIDX_W    = 3,
  parameter int LOCK_TOP  = 140,
  parameter int LOCK_STEP = 10,
  parameter int HYST      = 4,
  parameter int FOLD_TH   = 80,
  parameter int BASE_OFF  = 8,
  parameter int OFF_GAIN  = 2,
  parameter int MAX_OFF   = 100,
  parameter int TW        = 7
) (
  input  logic [FB_W-1:0]   fb_code,
  input  logic [VIDX_W-1:0] idx_q,
  input  vfs_mode_e         mode_q,
  output logic [VIDX_W-1:0] idx_n,
  output vfs_mode_e         mode_n,
  output logic [TW-1:0]     off_n
);
  localparam int NSTEP = VALLEY_MAX - 1;

  logic [NSTEP-1:0] below_dn;
  logic [NSTEP-1:0] below_up;

  // one comparator pair per valley step
  generate
    for (genvar g = 0; g < NSTEP; g++) begin : g_step
      localparam int STEP_TH = LOCK_TOP - g * LOCK_STEP;
      assign below_dn[g] = 32'(fb_code) < 32'(STEP_TH);
      assign below_up[g] = 32'(fb_code) < 32'(STEP_TH + HYST);
    end
  endgenerate

  logic [VIDX_W-1:0] tgt_dn;
  logic [VIDX_W-1:0] tgt_up;
  logic [31:0]       raw_off;
  logic              too_long;
  logic              folded;

  always_comb begin
    tgt_dn = VIDX_W'(1 + $countones(below_dn));
    tgt_up = VIDX_W'(1 + $countones(below_up));
    if (tgt_dn > idx_q)      idx_n = tgt_dn;
    else if (tgt_up < idx_q) idx_n = tgt_up;
    else                     idx_n = idx_q;

    if (32'(fb_code) < 32'(FOLD_TH))
      raw_off = 32'(BASE_OFF) + (32'(FOLD_TH) - 32'(fb_code)) * 32'(OFF_GAIN);
    else
      raw_off = 32'(BASE_OFF);
    too_long = raw_off > 32'(MAX_OFF);
    off_n    = too_long ? TW'(MAX_OFF) : TW'(raw_off);

    if (mode_q == VFS_VALLEY) folded = 32'(fb_code) < 32'(FOLD_TH);
    else                      folded = 32'(fb_code) < 32'(FOLD_TH + HYST);

    if (!folded)      mode_n = VFS_VALLEY;
    else if (too_long) mode_n = VFS_SKIP;
    else              mode_n = VFS_FOLD;
  end
endmodule

// File: rtl/vfs_switch_timer.sv
module vfs_switch_timer
  import vfs_pkg::*;
#(
  parameter int VIDX_W  = 3,
  parameter int TW      = 7,
  parameter int MAX_OFF = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bound,
  input  vfs_mode_e         mode_n,
  input  vfs_mode_e         mode_q,
  input  logic [VIDX_W-1:0] idx_q,
  input  logic [TW-1:0]     off_q,
  input  logic              valley_pulse,
  output logic              turn_on,
  output logic              floor_tick
);
  logic [TW-1:0]     tmr_q, tmr_n;
  logic [VIDX_W-1:0] vcnt_q, vcnt_n;
  logic              armed_q, armed_n;
  logic              ton_q, ton_n;

  always_comb begin
    tmr_n   = tmr_q;
    vcnt_n  = vcnt_q;
    armed_n = armed_q;
    ton_n   = 1'b0;
    if (bound) begin
      tmr_n   = '0;
      vcnt_n  = '0;
      armed_n = (mode_n != VFS_SKIP);
    end else begin
      if (tmr_q != TW'(MAX_OFF)) tmr_n = tmr_q + TW'(1);
      if (armed_q) begin
        case (mode_q)
          VFS_VALLEY: begin
            if (valley_pulse) begin
              if (vcnt_q + VIDX_W'(1) == idx_q) begin
                ton_n   = 1'b1;
                armed_n = 1'b0;
              end else begin
                vcnt_n = vcnt_q + VIDX_W'(1);
              end
            end
          end
          VFS_FOLD: begin
            if (tmr_q + TW'(1) == off_q) begin
              ton_n   = 1'b1;
              armed_n = 1'b0;
            end
          end
          default: armed_n = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      vcnt_q  <= '0;
      armed_q <= 1'b0;
      ton_q   <= 1'b0;
    end else begin
      tmr_q   <= tmr_n;
      vcnt_q  <= vcnt_n;
      armed_q <= armed_n;
      ton_q   <= ton_n;
    end
  end

  assign turn_on    = ton_q;
  assign floor_tick = (tmr_q == TW'(MAX_OFF - 1));
endmodule

// File: rtl/vly_foldback_sel.sv
module vly_foldback_sel
  import vfs_pkg::*;
#(
  parameter int FB_W       = 8,
  parameter int VALLEY_MAX = 6,
  parameter int LOCK_TOP   = 140,
  parameter int LOCK_STEP  = 10,
  parameter int HYST       = 4,
  parameter int FOLD_TH    = 80,
  parameter int BASE_OFF   = 8,
  parameter int OFF_GAIN   = 2,
  parameter int MAX_OFF    = 100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [FB_W-1:0]                  fb_code,
  input  logic                             valley_pulse,
  input  logic                             cycle_end,
  output logic                             turn_on,
  output logic [$clog2(VALLEY_MAX+1)-1:0]  valley_idx,
  output logic                             freeze,
  output logic                             skip
);
  localparam int VIDX_W = $clog2(VALLEY_MAX + 1);
  localparam int TW     = $clog2(MAX_OFF + 1);

  logic [VIDX_W-1:0] idx_q, idx_n;
  vfs_mode_e         mode_q, mode_n;
  logic [TW-1:0]     off_q, off_n;
  logic              floor_tick;
  logic              bound;

  vfs_level_map #(
    .FB_W(FB_W), .VALLEY_MAX(VALLEY_MAX), .VIDX_W(VIDX_W),
    .LOCK_TOP(LOCK_TOP), .LOCK_STEP(LOCK_STEP), .HYST(HYST),
    .FOLD_TH(FOLD_TH), .BASE_OFF(BASE_OFF), .OFF_GAIN(OFF_GAIN),
    .MAX_OFF(MAX_OFF), .TW(TW)
  ) map_i (
    .fb_code(fb_code), .idx_q(idx_q), .mode_q(mode_q),
    .idx_n(idx_n), .mode_n(mode_n), .off_n(off_n)
  );

  // boundary: external cycle end, or floor period elapsed while skipping
  assign bound = cycle_end | ((mode_q == VFS_SKIP) & floor_tick);

  vfs_switch_timer #(
    .VIDX_W(VIDX_W), .TW(TW), .MAX_OFF(MAX_OFF)
  ) tmr_i (
    .clk(clk), .rst_n(rst_n), .bound(bound),
    .mode_n(mode_n), .mode_q(mode_q), .idx_q(idx_q), .off_q(off_q),
    .valley_pulse(valley_pulse), .turn_on(turn_on), .floor_tick(floor_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= VIDX_W'(1);
      mode_q <= VFS_VALLEY;
      off_q  <= '0;
    end else if (bound) begin
      idx_q  <= idx_n;
      mode_q <= mode_n;
      off_q  <= off_n;
    end
  end

  assign valley_idx = idx_q;
  assign freeze     = (mode_q != VFS_VALLEY);
  assign skip       = (mode_q == VFS_SKIP);
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int VALLEY_MAX = 6
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cycle_end,
  input logic                            valley_pulse,
  input logic                            turn_on,
  input logic [$clog2(VALLEY_MAX+1)-1:0] valley_idx,
  input logic                            freeze,
  input logic                            skip
);
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(valley_idx) >= 32'd1) && (32'(valley_idx) <= 32'(VALLEY_MAX)));

  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cycle_end) && !$past(skip)) |-> $stable(valley_idx));

  assert_freeze_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze) |-> $past(cycle_end));

  assert_skip_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !turn_on);

  assert_valley_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_on && !freeze) |-> $past(valley_pulse));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on |=> !turn_on);
endmodule

bind vly_foldback_sel vfs_checker #(.VALLEY_MAX(VALLEY_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end), .valley_pulse(valley_pulse),
  .turn_on(turn_on), .valley_idx(valley_idx), .freeze(freeze), .skip(skip)
);

// File: tb/vly_foldback_sel_tb_top.sv
module vly_foldback_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_VMAX  = 6;
  localparam int TB_TOP   = 140;
  localparam int TB_STEP  = 10;
  localparam int TB_HYST  = 4;
  localparam int TB_FOLD  = 80;
  localparam int TB_BASE  = 8;
  localparam int TB_GAIN  = 2;
  localparam int TB_FLOOR = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] fb_code;
  logic       valley_pulse;
  logic       cycle_end;
  logic       turn_on;
  logic [2:0] valley_idx;
  logic       freeze;
  logic       skip;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int midx  = 1;
  int mmode = 0;
  int mtgt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vly_foldback_sel dut_i (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .valley_pulse(valley_pulse),
    .cycle_end(cycle_end), .turn_on(turn_on), .valley_idx(valley_idx),
    .freeze(freeze), .skip(skip)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected state from the requirement formulas
  task automatic model_update(input int f);
    int dn = 1;
    int up = 1;
    bit folded;
    int off;
    for (int k = 2; k <= TB_VMAX; k++) begin
      if (f < TB_TOP - (k-2)*TB_STEP) dn++;
      if (f < TB_TOP - (k-2)*TB_STEP + TB_HYST) up++;
    end
    if (dn > midx) midx = dn;
    else if (up < midx) midx = up;
    folded = (mmode == 0) ? (f < TB_FOLD) : (f < TB_FOLD + TB_HYST);
    if (folded) begin
      off = TB_BASE + ((f < TB_FOLD) ? (TB_FOLD - f) * TB_GAIN : 0);
      mmode = (off > TB_FLOOR) ? 2 : 1;
      mtgt = off;
    end else begin
      mmode = 0;
    end
  endtask

  task automatic check_state(input string req);
    check({req, " idx"}, int'(valley_idx), midx);
    check({req, " freeze"}, int'(freeze), (mmode != 0) ? 1 : 0);
    check({req, " skip"}, int'(skip), (mmode == 2) ? 1 : 0);
  endtask

  task automatic fold_timing(input string req);
    valley_pulse = 1'b1;
    for (int k = 1; k <= mtgt + 1; k++) begin
      @(negedge clk);
      check(req, int'(turn_on), (k == mtgt) ? 1 : 0);
    end
    valley_pulse = 1'b0;
  endtask

  task automatic run_point(input int f);
    @(negedge clk);
    fb_code = 8'(f);
    cycle_end = 1'b1;
    valley_pulse = 1'b1;           // coincident pulse must not count (R2)
    model_update(f);
    @(negedge clk);
    cycle_end = 1'b0;
    valley_pulse = 1'b0;
    check_state("R3 R4 R6 R8");
    if (mmode == 0) begin
      fb_code = 8'(255 - f);       // disturb inside the off period (R5)
      for (int p = 1; p <= midx; p++) begin
        @(negedge clk); valley_pulse = 1'b1;
        @(negedge clk); valley_pulse = 1'b0;
        check("R2 valley launch", int'(turn_on), (p == midx) ? 1 : 0);
      end
      check("R5 idx held", int'(valley_idx), midx);
      @(negedge clk);
      check("R9 one cycle", int'(turn_on), 0);
      valley_pulse = 1'b1;
      @(negedge clk); valley_pulse = 1'b0;
      check("R2 late pulse ignored", int'(turn_on), 0);
    end else if (mmode == 1) begin
      fb_code = 8'(255 - f);       // latched off time (R5)
      fold_timing("R7 foldback off time");
    end else begin
      for (int k = 1; k <= TB_FLOOR; k++) begin
        @(negedge clk);
        check("R8 no pulse in skip", int'(turn_on), 0);
      end
      model_update(f);
      check_state("R8 re-evaluated");
    end
  endtask

  initial begin
    rst_n = 1'b0;
    fb_code = 8'd255;
    valley_pulse = 1'b0;
    cycle_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idx", int'(valley_idx), 1);
    check("R1 freeze", int'(freeze), 0);
    check("R1 skip", int'(skip), 0);
    check("R1 turn_on", int'(turn_on), 0);

    for (int f = 255; f >= 0; f--) run_point(f);
    for (int f = 0; f <= 255; f++) run_point(f);

    // leave skip mode through the floor re-evaluation alone (R8)
    @(negedge clk);
    fb_code = 8'd10; cycle_end = 1'b1;
    model_update(10);
    @(negedge clk);
    cycle_end = 1'b0;
    check_state("R8 skip entry");
    for (int k = 1; k <= TB_FLOOR; k++) begin
      @(negedge clk);
      if (k == 50) fb_code = 8'd60;
    end
    model_update(60);
    check_state("R8 skip exit");
    fold_timing("R8 R7 timing after skip exit");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule